// File: doc/BRIEF.md
# Low-power real-time counter with seconds alarm

This block keeps wall-clock time in a 47-bit counter that advances on every edge of a slow, always-on clock. The top 32 bits are whole seconds and the bottom 15 bits are sub-second ticks, so one second is 32768 slow ticks. Software on a fast bus clock starts and stops the counter, presets it while it is stopped, and programs a 32-bit seconds alarm. When the running count enters the programmed second, a status flag is set. The flag drives an interrupt output and a wakeup output, each gated by its own enable bit. Both outputs come from the slow domain, so they still work when the bus clock is off.

Every bus write is a single-cycle strobe. It is carried into the slow domain by a toggle handshake, and a busy output stays high until the slow side has acted on the write. While busy is high, further writes are dropped.

All read data comes from a bus-domain copy of the slow-domain state. That copy is refreshed as one unit through a second handshake, so one read never mixes bits from two different ticks. Because of this, a control bit that was just written reads back its new value only after the write has crossed over and the copy has been refreshed. The two halves of the counter are separate reads, and a running counter can move between them; software re-reads until two readings agree.

Top module: `rtc_lp`

## Requirements
- R1: After reset, every register reads 0, and `alarm_irq` and `wakeup` are low.
- R2: While the counter is stopped:
  - a write to address 3 loads counter bits 31:0 from the write data;
  - a write to address 2 loads counter bits 46:32 from write-data bits 14:0;
  - a read of address 3 returns counter bits 31:0;
  - a read of address 2 returns counter bits 46:32 zero-extended to 32 bits;
  - the counter holds its value.
- R3: While control bit 0 (run) is 1, the counter advances by one on every slow clock edge and wraps from all ones to 0. Seconds are the counter shifted right by 15.
- R4: Writes to address 2 or 3 while the counter is running have no effect.
- R5: The control register is at address 0:
  - bit 0 is run, bit 1 is alarm enable, bit 3 is wakeup enable;
  - all other control bits read 0;
  - on the bus cycle right after a control write is accepted, a read still returns the old value;
  - the new value is visible only after the write has crossed into the slow domain.
- R6: The seconds alarm at address 4 is 32 bits. A write to it takes effect only while alarm enable is 0; otherwise it is ignored.
- R7: Status bit 0 (address 1) is the alarm flag. It is set on the slow cycle in which the running counter's seconds field becomes equal to the alarm value, whatever the enable bits are.
- R8: `alarm_irq` equals the alarm flag AND alarm enable. `wakeup` equals the alarm flag AND wakeup enable.
- R9: Writing status with bit 0 set clears the alarm flag. Writing status with bit 0 clear leaves the flag unchanged.
- R10: A write is accepted only on a bus cycle where `wr_busy` is low. `wr_busy` is high from the cycle after acceptance until the write has been applied in the slow domain. A write presented while `wr_busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-interface clock |
| slow_clk | input | 1 | Slow always-on counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational from the bus-domain copy) |
| wr_busy | output | 1 | A write is still crossing; new writes are dropped |
| alarm_irq | output | 1 | Alarm interrupt (slow domain) |
| wakeup | output | 1 | Wakeup request (slow domain) |

## Verification
The hardest event to reach from the ports is the alarm firing at a second boundary. From any ordinary start, reaching that boundary takes 32768 slow ticks. The stimulus gets there quickly by stopping the counter, loading a fraction a few ticks below rollover with the seconds one below the alarm, and then starting it.

Two other cases need exact bus timing. The first is a write dropped while busy, which needs two strobes on back-to-back bus cycles. The second is a control read-back taken on the very cycle after acceptance, before the write has crossed. Both are driven cycle by cycle with directed sequences, and random preset values check the counter split across its two registers.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_STAT   = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_CNT_LO = 3'd3,
    REG_ALARM  = 3'd4
  } reg_sel_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_ALM  = 1;
  localparam int CTL_WAKE = 3;
  localparam int STAT_ALM = 0;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/rtc_wr_xfer.sv
module rtc_wr_xfer #(
  parameter int PAY_W = 35
) (
  input  logic             b_clk,
  input  logic             b_rst_n,
  input  logic             b_req,
  input  logic [PAY_W-1:0] b_pay,
  output logic             b_busy,
  input  logic             s_clk,
  input  logic             s_rst_n,
  output logic             s_vld,
  output logic [PAY_W-1:0] s_pay
);
  logic             b_tog_q, b_tog_d;
  logic [PAY_W-1:0] b_pay_q;
  logic [1:0]       b_ack_q;
  logic [1:0]       s_sync_q;
  logic             s_seen_q;
  logic             accept;

  assign b_busy = b_tog_q ^ b_ack_q[1];
  assign accept = b_req & ~b_busy;

  always_comb begin
    b_tog_d = b_tog_q ^ accept;
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      b_tog_q <= 1'b0;
      b_ack_q <= 2'b00;
    end else begin
      b_tog_q <= b_tog_d;
      b_ack_q <= {b_ack_q[0], s_seen_q};
    end
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n)    b_pay_q <= '0;
    else if (accept) b_pay_q <= b_pay;
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_sync_q <= 2'b00;
      s_seen_q <= 1'b0;
    end else begin
      s_sync_q <= {s_sync_q[0], b_tog_q};
      s_seen_q <= s_sync_q[1];
    end
  end

  assign s_vld = s_sync_q[1] ^ s_seen_q;
  assign s_pay = b_pay_q;
endmodule

// File: rtl/rtc_snap_xfer.sv
module rtc_snap_xfer #(
  parameter int W = 83
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic [W-1:0] s_data,
  input  logic         b_clk,
  input  logic         b_rst_n,
  output logic [W-1:0] b_data
);
  logic         s_tog_q, s_tog_d;
  logic [W-1:0] s_hold_q;
  logic [1:0]   s_ack_q;
  logic         s_idle;
  logic [1:0]   b_sync_q;
  logic         b_seen_q;
  logic [W-1:0] b_data_q;
  logic         b_take;

  assign s_idle = ~(s_tog_q ^ s_ack_q[1]);

  always_comb begin
    s_tog_d = s_tog_q ^ s_idle;
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_tog_q <= 1'b0;
      s_ack_q <= 2'b00;
    end else begin
      s_tog_q <= s_tog_d;
      s_ack_q <= {s_ack_q[0], b_seen_q};
    end
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n)    s_hold_q <= '0;
    else if (s_idle) s_hold_q <= s_data;
  end

  assign b_take = b_sync_q[1] ^ b_seen_q;

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      b_sync_q <= 2'b00;
      b_seen_q <= 1'b0;
    end else begin
      b_sync_q <= {b_sync_q[0], s_tog_q};
      b_seen_q <= b_sync_q[1];
    end
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n)    b_data_q <= '0;
    else if (b_take) b_data_q <= s_hold_q;
  end

  assign b_data = b_data_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_lp_pkg::*;
#(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_vld,
  input  logic [SEL_W-1:0]        cmd_sel,
  input  logic [DATA_W-1:0]       cmd_data,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    run_o,
  output logic                    alm_en_o,
  output logic                    wake_en_o,
  output logic                    flag_o,
  output logic [CNT_W-FRAC_W-1:0] alarm_o,
  output logic                    irq_o,
  output logic                    wake_o
);
  localparam int SEC_W = CNT_W - FRAC_W;
  localparam int HI_W  = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [SEC_W-1:0] alarm_q, alarm_d;
  logic             run_q, run_d;
  logic             alm_en_q, alm_en_d;
  logic             wake_en_q, wake_en_d;
  logic             flag_q, flag_d;
  logic             enter_sec;

  assign cnt_inc   = cnt_q + CNT_ONE;
  assign enter_sec = run_q
                   && (cnt_inc[CNT_W-1:FRAC_W] == alarm_q)
                   && (cnt_q[CNT_W-1:FRAC_W] != alarm_q);

  always_comb begin
    cnt_d     = cnt_q;
    alarm_d   = alarm_q;
    run_d     = run_q;
    alm_en_d  = alm_en_q;
    wake_en_d = wake_en_q;
    flag_d    = flag_q;
    if (run_q) cnt_d = cnt_inc;
    if (cmd_vld) begin
      case (reg_sel_e'(cmd_sel))
        REG_CTRL: begin
          run_d     = cmd_data[CTL_RUN];
          alm_en_d  = cmd_data[CTL_ALM];
          wake_en_d = cmd_data[CTL_WAKE];
        end
        REG_STAT: begin
          if (cmd_data[STAT_ALM]) flag_d = 1'b0;
        end
        REG_CNT_LO: begin
          if (!run_q) cnt_d[DATA_W-1:0] = cmd_data;
        end
        REG_CNT_HI: begin
          if (!run_q) cnt_d[CNT_W-1:DATA_W] = cmd_data[HI_W-1:0];
        end
        REG_ALARM: begin
          if (!alm_en_q) alarm_d = cmd_data[SEC_W-1:0];
        end
        default: ;
      endcase
    end
    if (enter_sec) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      alarm_q   <= '0;
      run_q     <= 1'b0;
      alm_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      alarm_q   <= alarm_d;
      run_q     <= run_d;
      alm_en_q  <= alm_en_d;
      wake_en_q <= wake_en_d;
      flag_q    <= flag_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign alm_en_o  = alm_en_q;
  assign wake_en_o = wake_en_q;
  assign flag_o    = flag_q;
  assign alarm_o   = alarm_q;
  assign irq_o     = flag_q & alm_en_q;
  assign wake_o    = flag_q & wake_en_q;
endmodule

// File: rtl/rtc_lp.sv
module rtc_lp
  import rtc_lp_pkg::*;
#(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15,
  parameter int DATA_W = 32
) (
  input  logic              bus_clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_busy,
  output logic              alarm_irq,
  output logic              wakeup
);
  localparam int SEC_W  = CNT_W - FRAC_W;
  localparam int HI_W   = CNT_W - DATA_W;
  localparam int PAY_W  = SEL_W + DATA_W;
  localparam int SNAP_W = SEC_W + 4 + CNT_W;

  logic              b_rst_n, s_rst_n;
  logic              s_cmd_vld;
  logic [PAY_W-1:0]  s_cmd_pay;
  logic [CNT_W-1:0]  s_cnt;
  logic [SEC_W-1:0]  s_alarm;
  logic              s_run, s_alm_en, s_wake_en, s_flag;
  logic [SNAP_W-1:0] s_snap, b_snap;
  logic [CNT_W-1:0]  b_cnt;
  logic [SEC_W-1:0]  b_alarm;
  logic              b_run, b_alm_en, b_wake_en, b_flag;

  rtc_rst_sync #(.STAGES(2)) u_bus_rst (
    .clk(bus_clk), .arst_n(rst_n), .rst_n_o(b_rst_n)
  );

  rtc_rst_sync #(.STAGES(2)) u_slow_rst (
    .clk(slow_clk), .arst_n(rst_n), .rst_n_o(s_rst_n)
  );

  rtc_wr_xfer #(.PAY_W(PAY_W)) u_wr (
    .b_clk   (bus_clk),
    .b_rst_n (b_rst_n),
    .b_req   (bus_wr),
    .b_pay   ({bus_addr, bus_wdata}),
    .b_busy  (wr_busy),
    .s_clk   (slow_clk),
    .s_rst_n (s_rst_n),
    .s_vld   (s_cmd_vld),
    .s_pay   (s_cmd_pay)
  );

  rtc_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_core (
    .clk       (slow_clk),
    .rst_n     (s_rst_n),
    .cmd_vld   (s_cmd_vld),
    .cmd_sel   (s_cmd_pay[PAY_W-1:DATA_W]),
    .cmd_data  (s_cmd_pay[DATA_W-1:0]),
    .cnt_o     (s_cnt),
    .run_o     (s_run),
    .alm_en_o  (s_alm_en),
    .wake_en_o (s_wake_en),
    .flag_o    (s_flag),
    .alarm_o   (s_alarm),
    .irq_o     (alarm_irq),
    .wake_o    (wakeup)
  );

  assign s_snap = {s_alarm, s_flag, s_wake_en, s_alm_en, s_run, s_cnt};

  rtc_snap_xfer #(.W(SNAP_W)) u_snap (
    .s_clk   (slow_clk),
    .s_rst_n (s_rst_n),
    .s_data  (s_snap),
    .b_clk   (bus_clk),
    .b_rst_n (b_rst_n),
    .b_data  (b_snap)
  );

  assign {b_alarm, b_flag, b_wake_en, b_alm_en, b_run, b_cnt} = b_snap;

  always_comb begin
    bus_rdata = '0;
    case (reg_sel_e'(bus_addr))
      REG_CTRL: begin
        bus_rdata[CTL_RUN]  = b_run;
        bus_rdata[CTL_ALM]  = b_alm_en;
        bus_rdata[CTL_WAKE] = b_wake_en;
      end
      REG_STAT:   bus_rdata[STAT_ALM] = b_flag;
      REG_CNT_HI: bus_rdata[HI_W-1:0] = b_cnt[CNT_W-1:DATA_W];
      REG_CNT_LO: bus_rdata = b_cnt[DATA_W-1:0];
      REG_ALARM:  bus_rdata[SEC_W-1:0] = b_alarm;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_lp_chk.sv
module rtc_lp_chk #(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15
) (
  input logic                    s_clk,
  input logic                    s_rst_n,
  input logic                    b_clk,
  input logic                    b_rst_n,
  input logic [CNT_W-1:0]        cnt,
  input logic [CNT_W-FRAC_W-1:0] alarm,
  input logic                    run,
  input logic                    alm_en,
  input logic                    flag,
  input logic                    cmd_vld,
  input logic                    bus_wr,
  input logic                    wr_busy,
  input logic                    alarm_irq,
  input logic                    wakeup
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  AST_HOLD_STOPPED: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (!run && !cmd_vld) |=> $stable(cnt)); // R2

  AST_COUNT_STEP: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    run |=> (cnt == $past(cnt) + CNT_ONE)); // R3

  AST_ALARM_LOCK: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    alm_en |=> $stable(alarm)); // R6

  AST_FLAG_RISE: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $rose(flag) |-> (cnt[CNT_W-1:FRAC_W] == alarm)); // R7

  AST_OUT_GATED: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    !flag |-> (!alarm_irq && !wakeup)); // R8

  AST_BUSY_RISE: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    $rose(wr_busy) |-> $past(bus_wr)); // R10
endmodule

bind rtc_lp rtc_lp_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .s_clk     (slow_clk),
  .s_rst_n   (s_rst_n),
  .b_clk     (bus_clk),
  .b_rst_n   (b_rst_n),
  .cnt       (s_cnt),
  .alarm     (s_alarm),
  .run       (s_run),
  .alm_en    (s_alm_en),
  .flag      (s_flag),
  .cmd_vld   (s_cmd_vld),
  .bus_wr    (bus_wr),
  .wr_busy   (wr_busy),
  .alarm_irq (alarm_irq),
  .wakeup    (wakeup)
);

// File: tb/tb_rtc_lp.sv
`timescale 1ns/1ps
module tb_rtc_lp;
  logic        bus_clk, slow_clk, rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wr_busy, alarm_irq, wakeup;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_HI = 3'd2,
                         A_LO = 3'd3, A_ALM = 3'd4;

  rtc_lp dut (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wr_busy(wr_busy),
    .alarm_irq(alarm_irq), .wakeup(wakeup)
  );

  initial bus_clk = 1'b0;
  always #5 bus_clk = ~bus_clk;
  initial slow_clk = 1'b0;
  always #35 slow_clk = ~slow_clk;

  function automatic logic [31:0] hi_of(input logic [46:0] v);
    return {17'b0, v[46:32]};
  endfunction

  function automatic logic [31:0] ctrl_view(input logic [31:0] w);
    return w & 32'h0000_000B;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input logic [63:0] got,
                         input logic [63:0] lo, input logic [63:0] hi);
    total++;
    if (got < lo || got > hi) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h..%0h", tag, got, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    while (wr_busy) @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
    while (wr_busy) @(negedge bus_clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge bus_clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [46:0] v);
    logic [31:0] h, l;
    rd(A_HI, h);
    rd(A_LO, l);
    v = {h[14:0], l};
  endtask

  task automatic load(input logic [46:0] v);
    wr(A_HI, hi_of(v));
    wr(A_LO, v[31:0]);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [46:0] c0, c1, v;
    logic [31:0] s;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    #200;
    rst_n = 1'b1;
    settle(12);

    // R1 reset state
    rd(A_CTRL, r);  chk("R1 ctrl", r, 0);
    rd(A_STAT, r);  chk("R1 stat", r, 0);
    rd(A_HI, r);    chk("R1 cnt_hi", r, 0);
    rd(A_LO, r);    chk("R1 cnt_lo", r, 0);
    rd(A_ALM, r);   chk("R1 alarm", r, 0);
    chk("R1 irq", alarm_irq, 0);
    chk("R1 wake", wakeup, 0);

    // R5 read-back lags the crossing
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h1;
    @(negedge bus_clk);
    bus_wr = 1'b0;
    rd(A_CTRL, r);  chk("R5 old value right after accept", r, 0);
    while (wr_busy) @(negedge bus_clk);
    settle(12);
    rd(A_CTRL, r);  chk("R5 run reads back", r, 1);
    wr(A_CTRL, 32'hFFFF_FFF4);
    settle(12);
    rd(A_CTRL, r);  chk("R5 unused bits", r, ctrl_view(32'hFFFF_FFF4));
    wr(A_CTRL, 32'h0);
    settle(12);
    rd(A_CTRL, r);  chk("R5 stopped", r, 0);

    // R2 random presets while stopped, R6 random alarms with alarm enable off
    for (int i = 0; i < 20; i++) begin
      v = {$urandom_range(32767, 0), $urandom()};
      s = $urandom();
      load(v);
      wr(A_ALM, s);
      settle(12);
      rd(A_HI, r);  chk("R2 hi readback", r, hi_of(v));
      rd(A_LO, r);  chk("R2 lo readback", r, v[31:0]);
      rd(A_ALM, r); chk("R6 alarm accepted", r, s);
    end

    // R2 stopped counter holds
    rd_cnt(c0);
    settle(60);
    rd_cnt(c1);
    chk("R2 hold while stopped", c1, c0);

    // R3 progress while running
    load(47'd0);
    wr(A_CTRL, 32'h1);
    settle(12);
    rd_cnt(c0);
    settle(200);
    rd_cnt(c1);
    chk_rng("R3 advance per slow tick", c1 - c0, 190, 210);
    wr(A_CTRL, 32'h0);

    // R3 wrap at the top of the counter
    load({47{1'b1}});
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    settle(12);
    rd_cnt(c0);
    chk_rng("R3 wrap to zero", c0, 0, 200);

    // R4 loads ignored while running
    load(47'h0000_0000_1000);
    wr(A_CTRL, 32'h1);
    wr(A_LO, 32'hDEAD_0000);
    wr(A_HI, 32'h0000_7ABC);
    wr(A_CTRL, 32'h0);
    settle(12);
    rd(A_HI, r);  chk("R4 hi untouched", r, 0);
    rd(A_LO, r);  chk_rng("R4 lo untouched", r, 32'h1000, 32'h1000 + 1000);

    // R7 R8 alarm at a second boundary with both enables
    s = 32'h0000_1000;
    load({s - 32'd1, 15'h7FF0});
    wr(A_ALM, s);
    wr(A_CTRL, 32'hB);
    settle(40);
    rd(A_STAT, r);  chk("R7 flag set at boundary", r, 1);
    chk("R8 irq with enable", alarm_irq, 1);
    chk("R8 wake with enable", wakeup, 1);
    wr(A_CTRL, 32'h3);
    @(negedge bus_clk);
    chk("R8 wake gated off", wakeup, 0);
    chk("R8 irq still on", alarm_irq, 1);

    // R6 alarm write ignored while alarm enable is on
    wr(A_ALM, 32'h55);
    settle(12);
    rd(A_ALM, r);  chk("R6 alarm locked", r, s);

    // R9 clear behaviour
    wr(A_STAT, 32'h0);
    settle(12);
    rd(A_STAT, r);  chk("R9 zero write keeps flag", r, 1);
    wr(A_CTRL, 32'h1);
    @(negedge bus_clk);
    chk("R8 irq gated off", alarm_irq, 0);
    wr(A_STAT, 32'h1);
    settle(12);
    rd(A_STAT, r);  chk("R9 flag cleared", r, 0);

    // R7 flag sets with both enables off
    wr(A_CTRL, 32'h0);
    load({32'h0000_2221, 15'h7FF8});
    wr(A_ALM, 32'h0000_2222);
    wr(A_CTRL, 32'h1);
    settle(40);
    rd(A_STAT, r);  chk("R7 flag without enables", r, 1);
    chk("R8 irq off without enable", alarm_irq, 0);
    chk("R8 wake off without enable", wakeup, 0);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R10 back-to-back write is dropped
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = A_ALM; bus_wdata = 32'hA5A5_0001;
    @(negedge bus_clk);
    chk("R10 busy after accept", wr_busy, 1);
    bus_wdata = 32'h0BAD_0002;
    @(negedge bus_clk);
    bus_wr = 1'b0;
    while (wr_busy) @(negedge bus_clk);
    settle(12);
    rd(A_ALM, r);  chk("R10 second write dropped", r, 32'hA5A5_0001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule